// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the load-linked / store-conditional reservation state for a core with several hardware threads. Each thread owns one reservation: an address register that holds a 16-byte granule and a flag that says whether the reservation is live. A locked load from a thread records the granule of its physical address and arms that thread's flag. A conditional store from the same thread is then judged against that reservation. The block returns a result code to the pipeline and says whether the store may be sent on to memory.

Conditional stores to uncacheable space skip the reservation check. They always go through and return a separate code, which tells the pipeline to leave the destination register alone. A cacheable conditional store that fails reports why: the flag was clear, or the granule did not match. Each thread counts its consecutive failures. The block raises a one-cycle warning every tenth failure and a sticky fatal flag when a thread reaches the livelock limit. An external per-thread clear input models invalidation of a reservation by the rest of the system.

Requests are single-cycle pulses: at most one per cycle, tagged with a thread number. All outputs are registered and appear on the cycle after the request.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset, rsp_valid, warn_pulse and fatal_flag are 0 and every thread's flag is clear, so a cacheable conditional store from any thread fails with cause 1.
- R2: A locked load (req_is_sc=0) records the granule of req_addr for thread req_tid and arms its flag, replacing any older reservation of that thread. A following cacheable conditional store from that thread to the same granule returns code 1 (pass) with rsp_issue=1 and rsp_cause=0. Other threads' reservations are not touched.
- R3: Granules are 16 bytes. Addresses that differ only in bits [3:0] match. A difference in any bit from 4 upward is a mismatch, which fails with cause 2.
- R4: A conditional store with req_uncached=1 returns code 2 with rsp_issue=1 and rsp_cause=0 whatever the reservation holds. It changes neither the thread's flag nor its failure count.
- R5: A failing cacheable conditional store returns code 0 with rsp_issue=0 and clears the thread's flag, so the next store to the same granule fails with cause 1.
- R6: rsp_cause is 1 when the flag was clear and 2 on a granule mismatch with the flag set. When both conditions hold, the cause is 1.
- R7: A passing conditional store clears the thread's flag and resets that thread's consecutive-failure count to zero.
- R8: warn_pulse is 1 for exactly the response cycle of a failure whose incremented per-thread count is a nonzero multiple of 10. Each thread keeps its own count.
- R9: fatal_flag rises with the response to a thread's 5000th consecutive failure. It then stays 1 until reset, whatever the later traffic.
- R10: A pulse on bit t of res_clear clears thread t's flag. When a locked load of thread t arrives in the same cycle, the clear wins and the flag stays clear. The clear leaves other threads unaffected.
- R11: Every output changes exactly one clock edge after the request. rsp_valid is 1 only on the cycle after a conditional store. A locked load produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_is_sc | input | 1 | 1 = conditional store, 0 = locked load |
| req_tid | input | 2 | Requesting thread number |
| req_addr | input | 32 | Physical address of the access |
| req_uncached | input | 1 | Access targets uncacheable space |
| res_clear | input | 4 | Per-thread reservation invalidate, one bit per thread |
| rsp_valid | output | 1 | Response to a conditional store is present |
| rsp_code | output | 2 | 0 fail, 1 pass, 2 uncached (destination unchanged) |
| rsp_issue | output | 1 | Store may go on to memory |
| rsp_cause | output | 2 | 0 none, 1 flag was clear, 2 granule mismatch |
| warn_pulse | output | 1 | Tenth-failure warning, one cycle |
| fatal_flag | output | 1 | Sticky livelock indication |

## Verification
The hardest state to reach is the livelock limit. It needs 5000 consecutive failures on one thread with no pass in between. The bench gets there by sending back-to-back conditional stores on a thread whose flag was never armed. On each response it checks the warning against the running count modulo 10, and it checks that the fatal flag rises exactly at the limit. Per-thread independence of the counts, and the reset of a count by a pass, are shown by interleaving failures of two threads. A pass or an uncached store is placed one failure short of a warning, so the warning lands where the expected count puts it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        SC_FAIL     = 2'd0,
        SC_PASS     = 2'd1,
        SC_UNCACHED = 2'd2
    } sc_code_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_NOFLAG   = 2'd1,
        CAUSE_MISMATCH = 2'd2
    } fail_cause_e;

    typedef struct packed {
        sc_code_e    code;
        logic        issue;
        fail_cause_e cause;
        logic        pass;
        logic        fail;
    } sc_decision_t;

    function automatic sc_decision_t quiet_decision();
        sc_decision_t d;
        d.code  = SC_FAIL;
        d.issue = 1'b0;
        d.cause = CAUSE_NONE;
        d.pass  = 1'b0;
        d.fail  = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/llsc_sc_eval.sv
module llsc_sc_eval
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               sc_req,
    input  logic               uncached,
    input  logic               res_flag,
    input  logic [ADDR_W-1:0]  res_gran,
    input  logic [ADDR_W-1:0]  req_gran,
    output sc_decision_t       dec
);
    always_comb begin
        dec = quiet_decision();
        if (sc_req) begin
            if (uncached) begin
                dec.code  = SC_UNCACHED;
                dec.issue = 1'b1;
            end else if (!res_flag) begin
                dec.fail  = 1'b1;
                dec.cause = CAUSE_NOFLAG;
            end else if (req_gran != res_gran) begin
                dec.fail  = 1'b1;
                dec.cause = CAUSE_MISMATCH;
            end else begin
                dec.code  = SC_PASS;
                dec.issue = 1'b1;
                dec.pass  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_thread_slot.sv
module llsc_thread_slot #(
    parameter int ADDR_W      = 32,
    parameter int WARN_PERIOD = 10,
    parameter int FATAL_LIMIT = 5000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_i,
    input  logic [ADDR_W-1:0]  set_gran_i,
    input  logic               drop_i,
    input  logic               pass_i,
    input  logic               fail_i,
    output logic               flag_o,
    output logic [ADDR_W-1:0]  gran_o,
    output logic               warn_o,
    output logic               limit_o
);
    localparam int CNT_W = $clog2(FATAL_LIMIT + 1);
    localparam int MOD_W = $clog2(WARN_PERIOD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FATAL_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(FATAL_LIMIT);
    localparam logic [MOD_W-1:0] MOD_LAST = MOD_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] fail_cnt;
    logic [MOD_W-1:0] mod_cnt;

    assign warn_o  = fail_i && (mod_cnt == MOD_LAST);
    assign limit_o = fail_i && (fail_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            gran_o <= '0;
        end else begin
            if (set_i)
                gran_o <= set_gran_i;
            if (drop_i)
                flag_o <= 1'b0;
            else if (set_i)
                flag_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_cnt <= '0;
            mod_cnt  <= '0;
        end else if (pass_i) begin
            fail_cnt <= '0;
            mod_cnt  <= '0;
        end else if (fail_i) begin
            if (fail_cnt != CNT_TOP)
                fail_cnt <= fail_cnt + 1'b1;
            if (mod_cnt == MOD_LAST)
                mod_cnt <= '0;
            else
                mod_cnt <= mod_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int WARN_PERIOD = 10,
    parameter int FATAL_LIMIT = 5000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_is_sc,
    input  logic [$clog2(NUM_THREADS)-1:0] req_tid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic                          req_uncached,
    input  logic [NUM_THREADS-1:0]        res_clear,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_code,
    output logic                          rsp_issue,
    output logic [1:0]                    rsp_cause,
    output logic                          warn_pulse,
    output logic                          fatal_flag
);
    localparam int TID_W = $clog2(NUM_THREADS);
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0]      req_gran;
    logic                   sc_req;
    logic                   ll_req;
    logic [NUM_THREADS-1:0] flags;
    logic [ADDR_W-1:0]      grans [NUM_THREADS];
    logic [NUM_THREADS-1:0] warn_vec;
    logic [NUM_THREADS-1:0] limit_vec;
    sc_decision_t           dec;

    assign req_gran = req_addr & GRAN_MASK;
    assign sc_req   = req_valid && req_is_sc;
    assign ll_req   = req_valid && !req_is_sc;

    genvar t;
    generate
        for (t = 0; t < NUM_THREADS; t++) begin : g_slot
            logic hit;
            assign hit = (req_tid == TID_W'(t));
            llsc_thread_slot #(
                .ADDR_W      (ADDR_W),
                .WARN_PERIOD (WARN_PERIOD),
                .FATAL_LIMIT (FATAL_LIMIT)
            ) u_slot (
                .clk        (clk),
                .rst        (rst),
                .set_i      (ll_req && hit),
                .set_gran_i (req_gran),
                .drop_i     (res_clear[t] || (hit && (dec.pass || dec.fail))),
                .pass_i     (hit && dec.pass),
                .fail_i     (hit && dec.fail),
                .flag_o     (flags[t]),
                .gran_o     (grans[t]),
                .warn_o     (warn_vec[t]),
                .limit_o    (limit_vec[t])
            );
        end
    endgenerate

    llsc_sc_eval #(.ADDR_W(ADDR_W)) u_eval (
        .sc_req   (sc_req),
        .uncached (req_uncached),
        .res_flag (flags[req_tid]),
        .res_gran (grans[req_tid]),
        .req_gran (req_gran),
        .dec      (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_code   <= 2'd0;
            rsp_issue  <= 1'b0;
            rsp_cause  <= 2'd0;
            warn_pulse <= 1'b0;
            fatal_flag <= 1'b0;
        end else begin
            rsp_valid  <= sc_req;
            rsp_code   <= dec.code;
            rsp_issue  <= dec.issue;
            rsp_cause  <= dec.cause;
            warn_pulse <= |warn_vec;
            fatal_flag <= fatal_flag || (|limit_vec);
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_is_sc,
    input logic       req_uncached,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       rsp_issue,
    input logic [1:0] rsp_cause,
    input logic       warn_pulse,
    input logic       fatal_flag
);
    p_resp_follows_sc_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_sc) |=> rsp_valid);

    p_no_resp_otherwise_r11: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_is_sc) |=> (!rsp_valid && !warn_pulse));

    p_uncached_code_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_sc && req_uncached) |=> (rsp_code == 2'd2 && rsp_issue && rsp_cause == 2'd0));

    p_fail_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd0) |-> (!rsp_issue && rsp_cause != 2'd0));

    p_pass_issues_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_issue && rsp_cause == 2'd0));

    p_warn_on_fail_r8: assert property (@(posedge clk) disable iff (rst)
        warn_pulse |-> (rsp_valid && rsp_code == 2'd0));

    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        fatal_flag |=> fatal_flag);

    p_fatal_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fatal_flag) |-> (rsp_valid && rsp_code == 2'd0));
endmodule

bind llsc_monitor llsc_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_sc    (req_is_sc),
    .req_uncached (req_uncached),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_issue    (rsp_issue),
    .rsp_cause    (rsp_cause),
    .warn_pulse   (warn_pulse),
    .fatal_flag   (fatal_flag)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_is_sc = 1'b0;
    logic [1:0]  req_tid = '0;
    logic [31:0] req_addr = '0;
    logic        req_uncached = 1'b0;
    logic [3:0]  res_clear = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        rsp_issue;
    logic [1:0]  rsp_cause;
    logic        warn_pulse;
    logic        fatal_flag;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    llsc_monitor uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_sc(req_is_sc),
        .req_tid(req_tid), .req_addr(req_addr), .req_uncached(req_uncached),
        .res_clear(res_clear), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_issue(rsp_issue), .rsp_cause(rsp_cause), .warn_pulse(warn_pulse),
        .fatal_flag(fatal_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // expected response packed as {valid, code, issue, cause}
    task automatic chk_rsp(input string tag, input logic [1:0] code, input logic issue, input logic [1:0] cause);
        chk(tag, {26'd0, rsp_valid, rsp_code, rsp_issue, rsp_cause}, {26'd0, 1'b1, code, issue, cause});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        res_clear = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ll(input int t, input logic [31:0] a, input logic [3:0] clr);
        req_valid = 1'b1; req_is_sc = 1'b0; req_tid = 2'(t);
        req_addr = a; req_uncached = 1'b0; res_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; res_clear = '0;
    endtask

    task automatic sc(input int t, input logic [31:0] a, input logic unc);
        req_valid = 1'b1; req_is_sc = 1'b1; req_tid = 2'(t);
        req_addr = a; req_uncached = unc; res_clear = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_only(input logic [3:0] clr);
        res_clear = clr;
        @(negedge clk);
        res_clear = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] base;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
        chk("R1 warn after reset", {31'd0, warn_pulse}, 0);
        chk("R1 fatal after reset", {31'd0, fatal_flag}, 0);
        for (int t = 0; t < 4; t++) begin
            sc(t, 32'h2000_0000, 1'b0);
            chk_rsp("R1 sc with no reservation", 2'd0, 1'b0, 2'd1);
        end

        // R11: locked load gives no response; response lasts one cycle
        ll(0, 32'h3000_0000, 4'd0);
        chk("R11 no response to locked load", {31'd0, rsp_valid}, 0);
        sc(0, 32'h3000_0000, 1'b0);
        chk_rsp("R11 sc response next cycle", 2'd1, 1'b1, 2'd0);
        @(negedge clk);
        chk("R11 response drops", {31'd0, rsp_valid}, 0);

        // R2 R3: every offset inside the granule passes, on every thread
        for (int t = 0; t < 4; t++) begin
            base = 32'h1000_0040 + 32'(t) * 32'h100;
            for (int off = 0; off < 16; off++) begin
                ll(t, base + 32'((off * 7) % 16), 4'd0);
                sc(t, base + 32'(off), 1'b0);
                chk_rsp("R3 same granule passes", 2'd1, 1'b1, 2'd0);
            end
        end

        // R3 R6: any bit from 4 upward mismatches
        for (int t = 0; t < 4; t++) begin
            base = 32'h5A5A_5A50 ^ (32'(t) << 8);
            for (int b = 4; b < 32; b++) begin
                ll(t, base, 4'd0);
                sc(t, base ^ (32'd1 << b), 1'b0);
                chk_rsp("R3 granule mismatch", 2'd0, 1'b0, 2'd2);
            end
        end

        // R5 R6: after a mismatch the flag is clear; clear flag plus mismatch reports cause 1
        ll(1, 32'h0000_1230, 4'd0);
        sc(1, 32'h0000_4560, 1'b0);
        chk_rsp("R5 first failure mismatch", 2'd0, 1'b0, 2'd2);
        sc(1, 32'h0000_1230, 1'b0);
        chk_rsp("R5 flag cleared by failure", 2'd0, 1'b0, 2'd1);
        sc(1, 32'h0000_9990, 1'b0);
        chk_rsp("R6 clear flag wins over mismatch", 2'd0, 1'b0, 2'd1);

        // R2: thread isolation and override by newer locked load
        for (int t = 0; t < 4; t++)
            ll(t, 32'h7000_0000 + 32'(t) * 32'h40, 4'd0);
        for (int t = 0; t < 4; t++) begin
            sc(t, 32'h7000_0000 + 32'(t) * 32'h40, 1'b0);
            chk_rsp("R2 own reservation survives others", 2'd1, 1'b1, 2'd0);
        end
        ll(2, 32'h7100_0000, 4'd0);
        ll(3, 32'h7100_0000, 4'd0);
        ll(2, 32'h7200_0000, 4'd0);
        sc(2, 32'h7100_0000, 1'b0);
        chk_rsp("R2 newer load replaces granule", 2'd0, 1'b0, 2'd2);
        sc(3, 32'h7100_0008, 1'b0);
        chk_rsp("R2 other thread unaffected", 2'd1, 1'b1, 2'd0);

        // R7: pass clears flag
        ll(0, 32'h0000_0800, 4'd0);
        sc(0, 32'h0000_0800, 1'b0);
        chk_rsp("R7 pass", 2'd1, 1'b1, 2'd0);
        sc(0, 32'h0000_0800, 1'b0);
        chk_rsp("R7 flag cleared by pass", 2'd0, 1'b0, 2'd1);

        // R4: uncached leaves flag intact and returns code 2
        ll(0, 32'h0000_0A00, 4'd0);
        sc(0, 32'hFFFF_0000, 1'b1);
        chk_rsp("R4 uncached code", 2'd2, 1'b1, 2'd0);
        sc(0, 32'h0000_0A04, 1'b0);
        chk_rsp("R4 flag unchanged by uncached", 2'd1, 1'b1, 2'd0);
        sc(1, 32'h0000_0A04, 1'b1);
        chk_rsp("R4 uncached with clear flag", 2'd2, 1'b1, 2'd0);

        // R10: external clear, clear wins over same-cycle load, other thread untouched
        ll(0, 32'h0000_0C00, 4'd0);
        clear_only(4'b0001);
        sc(0, 32'h0000_0C00, 1'b0);
        chk_rsp("R10 clear drops reservation", 2'd0, 1'b0, 2'd1);
        ll(0, 32'h0000_0C00, 4'b0001);
        sc(0, 32'h0000_0C00, 1'b0);
        chk_rsp("R10 clear beats same-cycle load", 2'd0, 1'b0, 2'd1);
        ll(0, 32'h0000_0C00, 4'b0010);
        sc(0, 32'h0000_0C00, 1'b0);
        chk_rsp("R10 clear of other thread ignored", 2'd0 + 2'd1, 1'b1, 2'd0);

        // R8 R7 R4: warning timing, per-thread counts, reset by pass, untouched by uncached
        do_reset();
        for (int n = 1; n <= 5; n++) begin
            sc(2, 32'h0, 1'b0);
            chk("R8 thread2 early warn", {31'd0, warn_pulse}, 0);
        end
        for (int n = 1; n <= 9; n++) begin
            sc(3, 32'h0, 1'b0);
            chk("R8 thread3 warn before tenth", {31'd0, warn_pulse}, 0);
        end
        for (int n = 6; n <= 10; n++) begin
            sc(2, 32'h0, 1'b0);
            chk("R8 thread2 warn at count", {31'd0, warn_pulse}, (n == 10) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        chk("R8 warn is one cycle", {31'd0, warn_pulse}, 0);
        sc(3, 32'h0, 1'b1);
        chk("R4 uncached no warn", {31'd0, warn_pulse}, 0);
        sc(3, 32'h0, 1'b0);
        chk("R4 count kept across uncached", {31'd0, warn_pulse}, 1);
        for (int n = 1; n <= 9; n++) sc(1, 32'h0, 1'b0);
        ll(1, 32'h40, 4'd0);
        sc(1, 32'h40, 1'b0);
        for (int n = 1; n <= 10; n++) begin
            sc(1, 32'h0, 1'b0);
            chk("R7 count restarts after pass", {31'd0, warn_pulse}, (n == 10) ? 32'd1 : 32'd0);
        end

        // R9 R8: livelock limit on thread 0
        do_reset();
        begin
            int wrong_warn = 0;
            int wrong_fatal = 0;
            for (int n = 1; n <= 5003; n++) begin
                sc(0, 32'h0, 1'b0);
                if (warn_pulse !== ((n % 10) == 0)) wrong_warn++;
                if (fatal_flag !== (n >= 5000)) wrong_fatal++;
                if (n == 4999) chk("R9 no fatal before limit", {31'd0, fatal_flag}, 0);
                if (n == 5000) chk("R9 fatal at limit", {31'd0, fatal_flag}, 1);
            end
            chk("R8 warn pattern over long run", wrong_warn, 0);
            chk("R9 fatal pattern over long run", wrong_fatal, 0);
        end
        ll(0, 32'h80, 4'd0);
        sc(0, 32'h80, 1'b0);
        chk("R9 fatal held after pass", {31'd0, fatal_flag}, 1);
        do_reset();
        chk("R1 fatal cleared by reset", {31'd0, fatal_flag}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule